// File: doc/BRIEF.md
# Grayscale Dither Lookup Table

This block drives a one-bit monochrome panel from 3-bit gray pixels. For every pixel clock it looks up one pattern bit in a small programmable table and emits it as the on/off drive for that pixel. The bit it picks depends on three things. The first is the gray level. The second is a frame phase that cycles through four values. The third is the pixel's position inside a 2x2-bit (4x4 pixel) screen tile. Together these give temporal and spatial dithering, so intermediate gray levels appear as a mix of lit and dark pixels across space and time.

Software fills the table through a word-addressed register port before the display runs. The horizontal, vertical and frame position counters live inside the block. They are kept in step by a pixel-valid strobe, a line-start strobe and a frame-start strobe that come from the display timing logic. When a strobe arrives in the same cycle as a valid pixel, the strobe takes effect first, and that pixel is placed at the new position.

Top module: `gray_dither`

## Requirements
- R1: A synchronous reset clears the position counters and all 32 table words to zero, and holds `drive_bit` and `drive_valid` low.
- R2: When `reg_wr` is high, the table word at word address `reg_addr` takes `reg_wdata[15:0]`. `reg_rdata` shows the word at `reg_addr` in its low 16 bits, and its upper 16 bits read as zero.
- R3: Bits 31..16 of `reg_wdata` are discarded and never affect the stored word or the drive bit.
- R4: The word used for a pixel has word address frame*8 + pixel. This is byte offset frame*0x20 + pixel*4, so pixel 5 uses 0x14, 0x34, 0x54 and 0x74 in frames 0 to 3.
- R5: The bit taken from that word has index v*4 + h, where h and v are the horizontal and vertical tile positions. Position (0,0) uses bit 0 and position (3,3) uses bit 15.
- R6: The horizontal position advances by one, modulo 4, after each valid pixel. It holds its value when `pix_valid` is low.
- R7: `line_start` sets h to 0 and advances v by one, modulo 4. A pixel in the same cycle uses the new position.
- R8: `frame_start` sets h and v to 0 and advances the frame phase by one, modulo 4. The phase is 0 after reset. A pixel in the same cycle uses the new position. `frame_start` overrides `line_start`.
- R9: `drive_valid` equals `pix_valid` delayed by one clock. `drive_bit` is the looked-up bit delayed by one clock, and it is 0 whenever `drive_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | A pixel is present this cycle |
| pix_value | input | 3 | Gray level of the pixel |
| line_start | input | 1 | A new line begins this cycle |
| frame_start | input | 1 | A new frame begins this cycle |
| reg_wr | input | 1 | Write strobe for the table |
| reg_addr | input | 5 | Word address for write and readback |
| reg_wdata | input | 32 | Write data; only the low 16 bits are kept |
| reg_rdata | output | 32 | Readback of the addressed word, zero-extended |
| drive_bit | output | 1 | Registered on/off drive for the panel |
| drive_valid | output | 1 | Registered pixel-valid flag |

## Verification
The bench loads words with random upper bits. A design that stored or decoded those bits would read back wrong values or pick wrong drive bits. Every one of the 16 tile positions is reached, so a swapped h/v index or a wrong wrap would light the wrong pixel. Strobes are sent in the same cycle as pixels, and sometimes together. This catches a design that applies the strobe one pixel late or lets line start win over frame start. Pixel 5 is stepped through all four frame phases, and a table write is made during pixel flow. This exposes a wrong frame stride and a wrong one-clock latency.

// File: rtl/gdl_pkg.sv
package gdl_pkg;
    localparam int GDL_PIX_W   = 3;
    localparam int GDL_PHASE_W = 2;
    localparam int GDL_TILE_W  = 2;
    localparam int GDL_BUS_W   = 32;

    typedef struct packed {
        logic bit_v;
        logic valid;
    } drive_t;
endpackage

// File: rtl/gdl_pos_track.sv
module gdl_pos_track #(
    parameter int TILE_W  = 2,
    parameter int PHASE_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_valid,
    input  logic               line_start,
    input  logic               frame_start,
    output logic [TILE_W-1:0]  cur_h,
    output logic [TILE_W-1:0]  cur_v,
    output logic [PHASE_W-1:0] cur_f
);
    typedef struct packed {
        logic [TILE_W-1:0]  h;
        logic [TILE_W-1:0]  v;
        logic [PHASE_W-1:0] f;
    } pos_t;

    pos_t pos_q, pos_d, eff;

    always_comb begin
        eff = pos_q;
        if (frame_start) begin
            eff.h = '0;
            eff.v = '0;
            eff.f = pos_q.f + 1'b1;
        end else if (line_start) begin
            eff.h = '0;
            eff.v = pos_q.v + 1'b1;
        end
        pos_d   = eff;
        pos_d.h = eff.h + TILE_W'(pix_valid);
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_d;
    end

    assign cur_h = eff.h;
    assign cur_v = eff.v;
    assign cur_f = eff.f;

    a_r6_h_steps: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !line_start && !frame_start) |=> pos_q.h == TILE_W'($past(pos_q.h) + 1'b1));
    a_r6_h_holds: assert property (@(posedge clk) disable iff (rst)
        (!pix_valid && !line_start && !frame_start) |=> $stable(pos_q));
    a_r7_line_adv: assert property (@(posedge clk) disable iff (rst)
        (line_start && !frame_start) |=> pos_q.v == TILE_W'($past(pos_q.v) + 1'b1) && $stable(pos_q.f));
    a_r8_frame_adv: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> pos_q.v == '0 && pos_q.f == PHASE_W'($past(pos_q.f) + 1'b1));
endmodule

// File: rtl/gdl_pattern_table.sv
module gdl_pattern_table #(
    parameter int ADDR_W = 5,
    parameter int IDX_W  = 4,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] rw_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [ADDR_W-1:0] look_addr,
    input  logic [IDX_W-1:0]  look_idx,
    output logic              look_bit
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int PAT_W = 1 << IDX_W;

    logic [PAT_W-1:0] mem_q [WORDS];
    logic [PAT_W-1:0] mem_d [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[rw_addr] = wr_data[PAT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) mem_q <= '{default: '0};
        else     mem_q <= mem_d;
    end

    assign rd_data  = {{(BUS_W-PAT_W){1'b0}}, mem_q[rw_addr]};
    assign look_bit = mem_q[look_addr][look_idx];

    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem_q[$past(rw_addr)] == $past(wr_data[PAT_W-1:0]));
    a_r3_high_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[BUS_W-1:PAT_W] != '0) |=> rd_data[BUS_W-1:PAT_W] == '0);
endmodule

// File: rtl/gray_dither.sv
module gray_dither
    import gdl_pkg::*;
#(
    parameter int PIX_W   = GDL_PIX_W,
    parameter int PHASE_W = GDL_PHASE_W,
    parameter int TILE_W  = GDL_TILE_W,
    parameter int BUS_W   = GDL_BUS_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pix_valid,
    input  logic [PIX_W-1:0]         pix_value,
    input  logic                     line_start,
    input  logic                     frame_start,
    input  logic                     reg_wr,
    input  logic [PIX_W+PHASE_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]         reg_wdata,
    output logic [BUS_W-1:0]         reg_rdata,
    output logic                     drive_bit,
    output logic                     drive_valid
);
    localparam int ADDR_W = PIX_W + PHASE_W;
    localparam int IDX_W  = 2 * TILE_W;

    logic [TILE_W-1:0]  cur_h, cur_v;
    logic [PHASE_W-1:0] cur_f;
    logic               look_bit;
    drive_t             drv_q, drv_d;

    gdl_pos_track #(.TILE_W(TILE_W), .PHASE_W(PHASE_W)) u_pos (
        .clk(clk), .rst(rst), .pix_valid(pix_valid),
        .line_start(line_start), .frame_start(frame_start),
        .cur_h(cur_h), .cur_v(cur_v), .cur_f(cur_f)
    );

    gdl_pattern_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BUS_W(BUS_W)) u_tab (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .rw_addr(reg_addr),
        .wr_data(reg_wdata), .rd_data(reg_rdata),
        .look_addr({cur_f, pix_value}), .look_idx({cur_v, cur_h}),
        .look_bit(look_bit)
    );

    always_comb begin
        drv_d.valid = pix_valid;
        drv_d.bit_v = pix_valid & look_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) drv_q <= '0;
        else     drv_q <= drv_d;
    end

    assign drive_bit   = drv_q.bit_v;
    assign drive_valid = drv_q.valid;

    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> drive_valid == $past(pix_valid));
    a_r9_dark_idle: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !drive_bit);
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !drive_bit && !drive_valid);
endmodule

// File: tb/gray_dither_bench.sv
module gray_dither_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_valid = 1'b0;
    logic [2:0]  pix_value = '0;
    logic        line_start = 1'b0;
    logic        frame_start = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        drive_bit, drive_valid;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] mdl_mem [32];
    int mh = 0, mv = 0, mf = 0;

    always #10 clk = ~clk;

    gray_dither u_gray_dither (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_value(pix_value),
        .line_start(line_start), .frame_start(frame_start),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .drive_bit(drive_bit), .drive_valid(drive_valid)
    );

    function automatic logic expect_bit(int f, int v, int h, int p);
        return mdl_mem[f*8 + p][v*4 + h];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(int a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
        mdl_mem[a] = d[15:0];
    endtask

    task automatic rd_check(string req, int a);
        reg_addr = 5'(a);
        #1;
        check(req, reg_rdata, {16'h0, mdl_mem[a]});
    endtask

    task automatic step(string req, logic v, int p, logic ls, logic fs);
        logic eb;
        pix_valid = v; pix_value = 3'(p); line_start = ls; frame_start = fs;
        if (fs) begin mh = 0; mv = 0; mf = (mf + 1) % 4; end
        else if (ls) begin mh = 0; mv = (mv + 1) % 4; end
        eb = v ? expect_bit(mf, mv, mh, p) : 1'b0;
        if (v) mh = (mh + 1) % 4;
        @(posedge clk); @(negedge clk);
        pix_valid = 1'b0; line_start = 1'b0; frame_start = 1'b0;
        check(req, {30'h0, drive_valid, drive_bit}, {30'h0, v, eb});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) mdl_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 outputs", {30'h0, drive_valid, drive_bit}, 32'h0);
        for (int i = 0; i < 32; i++) rd_check("R1 table clear", i);
        step("R1 dark before programming", 1'b1, 7, 1'b0, 1'b0);

        // R2, R3: write and readback, upper bits dropped
        wr_word(3, 32'hABCD_1234);
        rd_check("R2 readback", 3);
        rd_check("R3 upper dropped", 3);
        for (int i = 0; i < 32; i++) wr_word(i, $urandom());
        for (int i = 0; i < 32; i++) rd_check("R2 readback all", i);

        // R5: sweep all 16 tile positions with walking-bit word
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 32; i++) mdl_mem[i] = '0;
        mh = 0; mv = 0; mf = 0;
        for (int k = 0; k < 16; k++) begin
            wr_word(2, 32'hFFFF_0000 | (32'h1 << k));
            for (int v = 0; v < 4; v++) begin
                for (int h = 0; h < 4; h++) step("R5 bit index", 1'b1, 2, (h == 0 && v != 0), (h == 0 && v == 0 && k != 0) || (k == 0 && v == 0 && h == 0 && 1'b0));
                step("R6 idle holds", 1'b0, 2, 1'b0, 1'b0);
            end
            // return to frame 0 after three more frame starts when needed
            for (int q = 0; q < 4; q++) if (mf != 0) step("R8 phase wrap", 1'b0, 0, 1'b0, 1'b1);
        end

        // R4: pixel 5 across four frame phases
        for (int f = 0; f < 4; f++) wr_word(f*8 + 5, 32'h0000_0001 << (f * 4));
        for (int f = 0; f < 4; f++) begin
            step("R4 frame stride", 1'b1, 5, 1'b0, 1'b1);
            for (int h = 1; h < 4; h++) step("R4 frame stride", 1'b1, 5, 1'b0, 1'b0);
        end

        // R7, R8: coincident strobes
        step("R7 line with pixel", 1'b1, 5, 1'b1, 1'b0);
        step("R8 frame over line", 1'b1, 5, 1'b1, 1'b1);
        step("R6 wrap", 1'b1, 4, 1'b0, 1'b0);

        // R9: write during pixel flow, random stream
        for (int i = 0; i < 32; i++) wr_word(i, $urandom());
        for (int n = 0; n < 4000; n++) begin
            logic v, ls, fs;
            int r;
            r  = $urandom_range(0, 99);
            v  = (r < 75);
            ls = ($urandom_range(0, 99) < 6);
            fs = ($urandom_range(0, 99) < 2);
            if ($urandom_range(0, 99) < 3) begin
                wr_word($urandom_range(0, 31), $urandom());
                rd_check("R3 random readback", int'(reg_addr));
            end
            step("R9 random stream", v, $urandom_range(0, 7), ls, fs);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule